// File: doc/BRIEF.md
# Start-of-Packet Descriptor Scanner

When a receive ring runs in look-ahead mode, the host may hand the controller several descriptors per packet. Only some of them mark where a packet may begin. After the final descriptor of one packet has been written, this block walks forward around the ring to the next entry whose start flag is set. The next packet's data is placed in that entry's buffer.

While it walks, the block ignores ownership when deciding whether to move on. A skipped entry that the controller owns has its ownership flag cleared by a write request, which hands it back to the host. A skipped entry that the host owns is left alone.

The walk ends at the first start entry. The block then reports that entry's index and whether the controller owns it; if the controller does not, the poll logic waits on that entry. With look-ahead mode off, the block reads only the entry after the last one used and reports it directly.

Top module: `sop_scan_top`

## Requirements
- R1: Out of reset, `rdReq`, `clrReq`, `doneStb`, `busy` and `scanErr` are all 0.
- R2: With `laMode`=0, a start issues exactly one descriptor read, of entry (`lastIdx`+1) mod `ringLen`. It issues no clear writes, and it reports that entry as `foundIdx`, with `foundOwned` equal to the entry's ownership bit (1 = controller owns) and `scanErr`=0.
- R3: With `laMode`=1, the first read is of entry (`lastIdx`+1) mod `ringLen`. Each further read goes to the following index, and the index returns to 0 after `ringLen`-1.
- R4: An examined entry with own=1 and start=0 gets exactly one clear write at its index. The scan then moves to the next entry.
- R5: An examined entry with own=0 and start=0 receives no write, and the scan moves to the next entry.
- R6: The scan stops at the first examined entry with start=1. It reports that entry's index with `foundOwned` equal to its ownership bit and `scanErr`=0, and it never writes to that entry.
- R7: No entry is examined twice in one scan. If `ringLen` entries are examined without finding start=1, the block finishes with `scanErr`=1 and `foundOwned`=0.
- R8: `rdReq` and `clrReq` are never high together. A clear write is acknowledged before the next read is issued. Each request is held, with its index stable, until `rdValid` or `clrAck` respectively.
- R9: `doneStb` is a single-cycle pulse at the end of every scan. The reported result stays stable until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laMode | input | 1 | Look-ahead mode enable, sampled at start |
| startStb | input | 1 | Begin a scan (accepted while idle) |
| lastIdx | input | IDX_W | Last descriptor used by the finished packet |
| ringLen | input | IDX_W+1 | Number of ring entries, 1 to 2**IDX_W |
| rdReq | output | 1 | Descriptor read request |
| rdIdx | output | IDX_W | Index being read |
| rdValid | input | 1 | Read data returned |
| rdOwn | input | 1 | Ownership bit of read entry (1 = controller) |
| rdStp | input | 1 | Start-of-packet bit of read entry |
| clrReq | output | 1 | Request to clear ownership of an entry |
| clrIdx | output | IDX_W | Index to clear |
| clrAck | input | 1 | Clear write accepted |
| doneStb | output | 1 | Scan finished pulse |
| foundIdx | output | IDX_W | Index of the entry to use next |
| foundOwned | output | 1 | Controller owns the found entry |
| scanErr | output | 1 | Whole ring searched, no start entry |
| busy | output | 1 | Scan in progress |

## Verification
The bench builds the block with IDX_W=3, so rings hold up to eight entries. With that size, every ring length from 1 to 8 can be combined with every last-index position and a dozen ownership/start patterns, in both modes. This brings into reach the wrap from the top entry to 0 and rings of one entry. It also covers patterns with no start entry at all, which force the error path, and runs where every skipped entry is owned, which forces a clear write between every pair of reads.

// File: rtl/sop_scan_pkg.sv
package sop_scan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CLEAR, ST_DONE} scanState_t;

  typedef struct packed {
    logic load;     // begin: index after lastIdx, counters cleared
    logic advance;  // step to next ring entry
    logic capture;  // record current entry as result
    logic setErr;   // record ring-exhausted result
  } dpCtl_t;
endpackage

// File: rtl/sop_scan_dp.sv
module sop_scan_dp
  import sop_scan_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [IDX_W-1:0] lastIdx,
  input  logic [IDX_W:0]   ringLen,
  input  logic             rdOwn,
  output logic [IDX_W-1:0] curIdx,
  output logic             lastEntry,
  output logic [IDX_W-1:0] foundIdx,
  output logic             foundOwned,
  output logic             scanErr
);
  localparam int CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] lenQ;
  logic [CNT_W-1:0] seenCnt;

  function automatic logic [IDX_W-1:0] nextOf(input logic [IDX_W-1:0] i,
                                              input logic [CNT_W-1:0] len);
    logic [CNT_W-1:0] inc;
    inc = {1'b0, i} + CNT_W'(1);
    return (inc >= len) ? '0 : inc[IDX_W-1:0];
  endfunction

  assign lastEntry = ((seenCnt + CNT_W'(1)) == lenQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ       <= '0;
      seenCnt    <= '0;
      curIdx     <= '0;
      foundIdx   <= '0;
      foundOwned <= 1'b0;
      scanErr    <= 1'b0;
    end else begin
      if (ctl.load) begin
        lenQ    <= ringLen;
        curIdx  <= nextOf(lastIdx, ringLen);
        seenCnt <= '0;
      end else if (ctl.advance) begin
        curIdx  <= nextOf(curIdx, lenQ);
        seenCnt <= seenCnt + CNT_W'(1);
      end
      if (ctl.capture) begin
        foundIdx   <= curIdx;
        foundOwned <= rdOwn;
        scanErr    <= 1'b0;
      end else if (ctl.setErr) begin
        foundIdx   <= curIdx;
        foundOwned <= 1'b0;
        scanErr    <= 1'b1;
      end
    end
  end

  // R3: walk stays inside the ring
  p_idx_in_ring_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lenQ != '0) |-> ({1'b0, curIdx} < lenQ));
  // R7: never examines more entries than the ring holds
  p_seen_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lenQ != '0) |-> (seenCnt < lenQ));
  // R9: result only moves on capture/error
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.capture || ctl.setErr) |=> $stable(foundIdx) && $stable(scanErr));
endmodule

// File: rtl/sop_scan_ctrl.sv
module sop_scan_ctrl
  import sop_scan_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   laMode,
  input  logic   startStb,
  input  logic   rdValid,
  input  logic   rdOwn,
  input  logic   rdStp,
  input  logic   clrAck,
  input  logic   lastEntry,
  output dpCtl_t ctl,
  output logic   rdReq,
  output logic   clrReq,
  output logic   doneStb,
  output logic   busy
);
  scanState_t state, stateNxt;
  logic laQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      laQ   <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && startStb) laQ <= laMode;
    end
  end

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    rdReq    = 1'b0;
    clrReq   = 1'b0;
    doneStb  = 1'b0;
    unique case (state)
      ST_IDLE: if (startStb) begin
        ctl.load = 1'b1;
        stateNxt = ST_READ;
      end
      ST_READ: begin
        rdReq = 1'b1;
        if (rdValid) begin
          if (!laQ || rdStp) begin
            ctl.capture = 1'b1;
            stateNxt    = ST_DONE;
          end else if (rdOwn) begin
            stateNxt = ST_CLEAR;
          end else if (lastEntry) begin
            ctl.setErr = 1'b1;
            stateNxt   = ST_DONE;
          end else begin
            ctl.advance = 1'b1;
          end
        end
      end
      ST_CLEAR: begin
        clrReq = 1'b1;
        if (clrAck) begin
          if (lastEntry) begin
            ctl.setErr = 1'b1;
            stateNxt   = ST_DONE;
          end else begin
            ctl.advance = 1'b1;
            stateNxt    = ST_READ;
          end
        end
      end
      ST_DONE: begin
        doneStb  = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R8: read and clear never overlap
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && clrReq));
  // R4: a clear only follows an owned, non-start entry in look-ahead mode
  p_clr_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clrReq) |-> $past(rdValid && rdOwn && !rdStp && laQ));
  // R9: done is a single pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);
  // R2: plain mode never clears
  p_plain_noclr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !laQ) |-> !clrReq);
endmodule

// File: rtl/sop_scan_top.sv
module sop_scan_top
  import sop_scan_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             laMode,
  input  logic             startStb,
  input  logic [IDX_W-1:0] lastIdx,
  input  logic [IDX_W:0]   ringLen,
  output logic             rdReq,
  output logic [IDX_W-1:0] rdIdx,
  input  logic             rdValid,
  input  logic             rdOwn,
  input  logic             rdStp,
  output logic             clrReq,
  output logic [IDX_W-1:0] clrIdx,
  input  logic             clrAck,
  output logic             doneStb,
  output logic [IDX_W-1:0] foundIdx,
  output logic             foundOwned,
  output logic             scanErr,
  output logic             busy
);
  dpCtl_t           ctl;
  logic             lastEntry;
  logic [IDX_W-1:0] curIdx;

  sop_scan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .laMode(laMode), .startStb(startStb),
    .rdValid(rdValid), .rdOwn(rdOwn), .rdStp(rdStp), .clrAck(clrAck),
    .lastEntry(lastEntry), .ctl(ctl), .rdReq(rdReq), .clrReq(clrReq),
    .doneStb(doneStb), .busy(busy)
  );

  sop_scan_dp #(.IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lastIdx(lastIdx), .ringLen(ringLen),
    .rdOwn(rdOwn), .curIdx(curIdx), .lastEntry(lastEntry),
    .foundIdx(foundIdx), .foundOwned(foundOwned), .scanErr(scanErr)
  );

  assign rdIdx  = curIdx;
  assign clrIdx = curIdx;

  // R8: requests held with stable index until answered
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> rdReq && $stable(rdIdx));
  p_clr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !clrAck) |=> clrReq && $stable(clrIdx));
endmodule

// File: tb/sop_scan_top_tb.sv
module sop_scan_top_tb;
  localparam int IDX_W = 3;
  localparam int NENT  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic laMode = 1'b0, startStb = 1'b0;
  logic [IDX_W-1:0] lastIdx = '0;
  logic [IDX_W:0]   ringLen = 1;
  logic rdReq, clrReq, doneStb, foundOwned, scanErr, busy;
  logic [IDX_W-1:0] rdIdx, clrIdx, foundIdx;
  logic rdValid = 1'b0, rdOwn = 1'b0, rdStp = 1'b0, clrAck = 1'b0;

  logic ownM [NENT];
  logic stpM [NENT];
  int rdCnt, clrCnt, firstRd, cycles;
  int nTests = 0, nFail = 0;

  always #2 clk = ~clk;  // 250 MHz

  sop_scan_top #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rstN(rstN), .laMode(laMode), .startStb(startStb),
    .lastIdx(lastIdx), .ringLen(ringLen), .rdReq(rdReq), .rdIdx(rdIdx),
    .rdValid(rdValid), .rdOwn(rdOwn), .rdStp(rdStp), .clrReq(clrReq),
    .clrIdx(clrIdx), .clrAck(clrAck), .doneStb(doneStb), .foundIdx(foundIdx),
    .foundOwned(foundOwned), .scanErr(scanErr), .busy(busy)
  );

  // descriptor memory responder
  always @(negedge clk) begin
    if (rdValid) rdValid = 1'b0;
    else if (rdReq) begin
      if (rdCnt == 0) firstRd = int'(rdIdx);
      rdCnt++;
      rdOwn   = ownM[rdIdx];
      rdStp   = stpM[rdIdx];
      rdValid = 1'b1;
    end
    if (clrAck) clrAck = 1'b0;
    else if (clrReq) begin
      ownM[clrIdx] = 1'b0;
      clrCnt++;
      clrAck = 1'b1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runScan(input logic la, input int len, input int last, input int pat);
    logic expOwn [NENT];
    int idx, n, expRd, expClr, expFound, expOwned, expErr, waitC, fIdx;
    for (int i = 0; i < NENT; i++) begin
      if (pat == 10)      begin stpM[i] = 1'b0; ownM[i] = 1'b1; end
      else if (pat == 11) begin stpM[i] = 1'b0; ownM[i] = (i % 2 == 0); end
      else begin
        stpM[i] = ((i * 3 + pat) % 7 == 0);
        ownM[i] = ((i + pat) % 3 != 0);
      end
      expOwn[i] = ownM[i];
    end
    idx = (last + 1) % len; n = 0; expRd = 0; expClr = 0;
    expFound = 0; expOwned = 0; expErr = 0;
    forever begin
      expRd++;
      if (!la || stpM[idx]) begin expFound = idx; expOwned = int'(ownM[idx]); break; end
      if (ownM[idx]) begin expOwn[idx] = 1'b0; expClr++; end
      n++;
      if (n == len) begin expErr = 1; break; end
      idx = (idx + 1) % len;
    end
    rdCnt = 0; clrCnt = 0; firstRd = -1;
    @(negedge clk);
    laMode = la; ringLen = (IDX_W+1)'(len); lastIdx = IDX_W'(last); startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    waitC = 0;
    while (!doneStb && waitC < 200) begin @(negedge clk); waitC++; end
    check(la ? "R9 done" : "R2 done", int'(doneStb), 1);
    check(la ? "R3 first read" : "R2 first read", firstRd, (last + 1) % len);
    check(la ? "R7 read count" : "R2 read count", rdCnt, expRd);
    check(la ? "R4 clear count" : "R2 clear count", clrCnt, expClr);
    check("R7 error flag", int'(scanErr), expErr);
    if (expErr == 0) begin
      check(la ? "R6 found index" : "R2 found index", int'(foundIdx), expFound);
      check(la ? "R6 found owned" : "R2 found owned", int'(foundOwned), expOwned);
    end else check("R7 owned on error", int'(foundOwned), 0);
    for (int i = 0; i < NENT; i++)
      check("R5 memory state", int'(ownM[i]), int'(expOwn[i]));
    fIdx = int'(foundIdx);
    @(negedge clk);
    check("R9 pulse width", int'(doneStb), 0);
    check("R9 result hold", int'(foundIdx), fIdx);
    check("R8 idle no clear", int'(clrReq), 0);
  endtask

  initial begin
    cycles = 0; rdCnt = 0; clrCnt = 0; firstRd = -1;
    for (int i = 0; i < NENT; i++) begin ownM[i] = 1'b0; stpM[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdReq", int'(rdReq), 0);
    check("R1 clrReq", int'(clrReq), 0);
    check("R1 doneStb", int'(doneStb), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 scanErr", int'(scanErr), 0);
    for (int la = 0; la < 2; la++)
      for (int len = 1; len <= NENT; len++)
        for (int last = 0; last < len; last++)
          for (int pat = 0; pat < 12; pat++)
            runScan(la[0], len, last, pat);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule